// File: doc/BRIEF.md
# Channel Configuration Command Controller

This block accepts per-channel configuration commands from a host through a small synchronous register port. The host loads a channel number, a set of parameter words and a control word. The 4-bit command field in the control word starts the work. The controller keeps an internal store with the parameter words and the input mode of every channel, and a ready bit for each channel. When a command can not be carried out safely it reports a configuration error code and leaves the store as it was. Two further command codes pick the mains-frequency setting that the filters elsewhere use.

A differential input uses two adjacent channels and is always addressed by its even channel. The whole pair is configured and cleared as one unit. A channel that is already configured must be cleared before its single-ended or differential mode changes. Once a command is finished, the command field reads back as zero, which is the ready code. While a command is running, the host port accepts no writes.

The sequencer has six states. IDLE waits for a nonzero command field and latches the operands (IDLE to CHECK). CHECK validates the operands. On an error it goes to DONE. Otherwise it moves to RESET, READ or WRITE, or straight to DONE for the frequency codes and unused codes. RESET spends one cycle and then goes to DONE. READ and WRITE step through one parameter word per cycle and go to DONE after the last word. DONE clears the command field and returns to IDLE.

Top module: `ccc_top`

## Requirements
- R1: After reset:
  - every ready bit is 0;
  - the error code is 0 and the 60 Hz flag is 1;
  - the control word reads 0 and busy is low.
- R2: Host addresses, with P = NUM_PARAM:
  - 0..P-1 hold the parameter words;
  - P holds the channel number;
  - P+1 holds the control word (command in bits 15:12, root flag in bit 7, differential in bit 8, unipolar in bit 9);
  - P+2 holds the ready bits (bit n is channel n);
  - P+3 holds the error code in bits 1:0 and the 60 Hz flag in bit 4.
  A WRITE (command 3) stores all parameter words for the channel and sets its ready bit.
- R3: A READ (command 2) copies the stored parameter words of the selected channel into the parameter registers.
- R4: A RESET (command 1) clears the channel's ready bit and its stored parameter words to zero.
- R5: When a command has finished, busy is low and the command field reads back as 0 (READY).
- R6: A differential WRITE to an even channel n sets the ready bits of n and n+1. A differential RESET of n clears both bits.
- R7: When the differential bit is set with an odd channel number on RESET, READ or WRITE:
  - the error code becomes 1 and cfg_err goes high;
  - nothing is changed.
- R8: A WRITE that has the root flag set while bit 9 selects bipolar gives error code 2 and is not carried out. The same WRITE with bit 9 set is accepted.
- R9: A WRITE whose single-ended/differential mode differs from that of an already configured target gives error code 3 and is not carried out. After the target is reset, the same WRITE is accepted.
- R10: Command 4 selects 50 Hz, so the 60 Hz flag reads 0. Command 5 selects 60 Hz, so the flag reads 1.
- R11: Host writes to any register are ignored while a command is pending or running.
- R12: The error code returns to 0 when the next command is accepted and completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_we | input | 1 | Register write strobe |
| host_addr | input | ADDR_W | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_addr (combinational) |
| busy | output | 1 | High while a command is pending or running |
| chan_ready | output | NUM_CH | Ready bit of each channel |
| cfg_err | output | 1 | High while the error code is nonzero |
| err_code | output | 2 | Error code of the last command |
| line_60hz | output | 1 | Mains-frequency selection, 1 = 60 Hz |

## Verification
The assertions assume that reset is asserted before the first clock edge. They also assume the host writes only through host_we and host_addr, so the channel register can change only through an accepted write. The pair-consistency property assumes NUM_CH is even. The stimulus starts with a reset pulse and drives every input on the falling edge. It issues each command and then waits for busy to drop. The only writes made during a busy window are the deliberate ones that test R11.

// File: rtl/ccc_pkg.sv
package ccc_pkg;
    localparam int DW        = 16;
    localparam int CMD_LSB   = 12;
    localparam int BIT_ROOT  = 7;
    localparam int BIT_DIFF  = 8;
    localparam int BIT_UNI   = 9;
    localparam int FREQ_BIT  = 4;
    localparam logic [DW-1:0] RSV_MASK = 16'h0C00;

    localparam logic [3:0] CMD_READY = 4'd0;
    localparam logic [3:0] CMD_RESET = 4'd1;
    localparam logic [3:0] CMD_READ  = 4'd2;
    localparam logic [3:0] CMD_WRITE = 4'd3;
    localparam logic [3:0] CMD_F50   = 4'd4;
    localparam logic [3:0] CMD_F60   = 4'd5;

    typedef enum logic [1:0] {
        ERR_NONE         = 2'd0,
        ERR_ODD_PAIR     = 2'd1,
        ERR_ROOT_BIPOLAR = 2'd2,
        ERR_MODE_SWITCH  = 2'd3
    } err_e;

    typedef enum logic [2:0] {
        S_IDLE, S_CHECK, S_RESET, S_READ, S_WRITE, S_DONE
    } state_e;
endpackage

// File: rtl/ccc_host_regs.sv
module ccc_host_regs
    import ccc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_PARAM = 7,
    parameter int ADDR_W    = 4,
    parameter int CH_W      = 4,
    parameter int IDX_W     = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [DW-1:0]           wdata,
    output logic [DW-1:0]           rdata,
    input  logic                    fsm_busy,
    input  logic                    done,
    input  logic                    ld_en,
    input  logic [IDX_W-1:0]        ld_idx,
    input  logic [DW-1:0]           ld_data,
    input  logic [NUM_CH-1:0]       status,
    input  logic [1:0]              err,
    input  logic                    line60,
    output logic                    busy,
    output logic [3:0]              cmd,
    output logic [CH_W-1:0]         chan,
    output logic                    diff,
    output logic                    uni,
    output logic                    root,
    output logic [NUM_PARAM*DW-1:0] param_flat
);
    localparam logic [ADDR_W-1:0] A_CHAN = ADDR_W'(NUM_PARAM);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(NUM_PARAM + 1);
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(NUM_PARAM + 2);
    localparam logic [ADDR_W-1:0] A_ERR  = ADDR_W'(NUM_PARAM + 3);

    logic [DW-1:0] par_q [NUM_PARAM];
    logic [DW-1:0] chan_q, ctrl_q;
    logic          blocked, host_ok;

    assign blocked = fsm_busy || (ctrl_q[DW-1:CMD_LSB] != CMD_READY);
    assign busy    = blocked;
    assign host_ok = we && !blocked;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_PARAM; i++) par_q[i] <= '0;
            chan_q <= '0;
            ctrl_q <= '0;
        end else begin
            if (host_ok) begin
                if (addr < A_CHAN)       par_q[addr[IDX_W-1:0]] <= wdata;
                else if (addr == A_CHAN) chan_q <= wdata;
                else if (addr == A_CTRL) ctrl_q <= wdata & ~RSV_MASK;
            end
            if (ld_en) par_q[ld_idx] <= ld_data;
            if (done)  ctrl_q[DW-1:CMD_LSB] <= CMD_READY;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < A_CHAN)       rdata = par_q[addr[IDX_W-1:0]];
        else if (addr == A_CHAN) rdata = chan_q;
        else if (addr == A_CTRL) rdata = ctrl_q;
        else if (addr == A_STAT) rdata[NUM_CH-1:0] = status;
        else if (addr == A_ERR) begin
            rdata[1:0]      = err;
            rdata[FREQ_BIT] = line60;
        end
    end

    assign cmd  = ctrl_q[DW-1:CMD_LSB];
    assign chan = chan_q[CH_W-1:0];
    assign diff = ctrl_q[BIT_DIFF];
    assign uni  = ctrl_q[BIT_UNI];
    assign root = ctrl_q[BIT_ROOT];

    for (genvar g = 0; g < NUM_PARAM; g++) begin : g_flat
        assign param_flat[g*DW +: DW] = par_q[g];
    end

    AST_BUSY_HOLDS_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        (blocked && we) |=> $stable(chan_q)); // R11
endmodule

// File: rtl/ccc_cfg_store.sv
module ccc_cfg_store
    import ccc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_PARAM = 7,
    parameter int CH_W      = 4,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CH_W-1:0]   ch,
    input  logic [IDX_W-1:0]  idx,
    input  logic              wr_en,
    input  logic [DW-1:0]     wr_data,
    output logic [DW-1:0]     rd_data,
    input  logic              set_en,
    input  logic              clr_en,
    input  logic              pair,
    output logic [NUM_CH-1:0] cfg_o,
    output logic [NUM_CH-1:0] dmode_o
);
    logic [DW-1:0]     mem [NUM_CH][NUM_PARAM];
    logic [NUM_CH-1:0] cfg_q, dm_q;
    logic [CH_W-1:0]   ch_even, ch_odd;
    logic              clr_pair;

    assign ch_even  = {ch[CH_W-1:1], 1'b0};
    assign ch_odd   = {ch[CH_W-1:1], 1'b1};
    assign clr_pair = pair || dm_q[ch];
    assign rd_data  = mem[ch][idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
            dm_q  <= '0;
            for (int c = 0; c < NUM_CH; c++)
                for (int p = 0; p < NUM_PARAM; p++) mem[c][p] <= '0;
        end else begin
            if (wr_en) mem[ch][idx] <= wr_data;
            if (set_en) begin
                if (pair) begin
                    cfg_q[ch_even] <= 1'b1;  dm_q[ch_even] <= 1'b1;
                    cfg_q[ch_odd]  <= 1'b1;  dm_q[ch_odd]  <= 1'b1;
                end else begin
                    cfg_q[ch] <= 1'b1;       dm_q[ch] <= 1'b0;
                end
            end
            if (clr_en) begin
                if (clr_pair) begin
                    cfg_q[ch_even] <= 1'b0;  dm_q[ch_even] <= 1'b0;
                    cfg_q[ch_odd]  <= 1'b0;  dm_q[ch_odd]  <= 1'b0;
                    for (int p = 0; p < NUM_PARAM; p++) begin
                        mem[ch_even][p] <= '0;
                        mem[ch_odd][p]  <= '0;
                    end
                end else begin
                    cfg_q[ch] <= 1'b0;       dm_q[ch] <= 1'b0;
                    for (int p = 0; p < NUM_PARAM; p++) mem[ch][p] <= '0;
                end
            end
        end
    end

    assign cfg_o   = cfg_q;
    assign dmode_o = dm_q;

    for (genvar k = 0; k < NUM_CH / 2; k++) begin : g_pair_chk
        AST_PAIR_LINKED: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_q[2*k] && dm_q[2*k]) |-> (cfg_q[2*k+1] && dm_q[2*k+1])); // R6
    end
endmodule

// File: rtl/ccc_cmd_fsm.sv
module ccc_cmd_fsm
    import ccc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_PARAM = 7,
    parameter int CH_W      = 4,
    parameter int IDX_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        cmd_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              diff_i,
    input  logic              uni_i,
    input  logic              root_i,
    input  logic [NUM_CH-1:0] cfg_i,
    input  logic [NUM_CH-1:0] dmode_i,
    output logic              fsm_busy,
    output logic              done,
    output logic              ld_en,
    output logic              wr_en,
    output logic              set_en,
    output logic              clr_en,
    output logic              pair_o,
    output logic [CH_W-1:0]   ch_o,
    output logic [IDX_W-1:0]  idx_o,
    output err_e              err_o,
    output logic              line60_o
);
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_PARAM - 1);

    state_e          state_q, state_d;
    logic [CH_W-1:0] ch_q, ch1;
    logic            diff_q, uni_q, root_q, line60_q;
    logic [3:0]      cmd_q;
    logic [IDX_W-1:0] idx_q;
    err_e            err_q, err_chk;
    logic            chan_cmd, mode_clash;

    assign ch1      = {ch_q[CH_W-1:1], 1'b1};
    assign chan_cmd = (cmd_q == CMD_RESET) || (cmd_q == CMD_READ) || (cmd_q == CMD_WRITE);
    assign mode_clash = diff_q ?
        ((cfg_i[ch_q] && !dmode_i[ch_q]) || (cfg_i[ch1] && !dmode_i[ch1])) :
        (cfg_i[ch_q] && dmode_i[ch_q]);

    always_comb begin
        err_chk = ERR_NONE;
        if (diff_q && ch_q[0])                            err_chk = ERR_ODD_PAIR;
        else if (cmd_q == CMD_WRITE && root_q && !uni_q)  err_chk = ERR_ROOT_BIPOLAR;
        else if (cmd_q == CMD_WRITE && mode_clash)        err_chk = ERR_MODE_SWITCH;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (cmd_i != CMD_READY) state_d = S_CHECK;
            S_CHECK: begin
                if (chan_cmd && err_chk != ERR_NONE) state_d = S_DONE;
                else if (cmd_q == CMD_RESET)         state_d = S_RESET;
                else if (cmd_q == CMD_READ)          state_d = S_READ;
                else if (cmd_q == CMD_WRITE)         state_d = S_WRITE;
                else                                 state_d = S_DONE;
            end
            S_RESET: state_d = S_DONE;
            S_READ,
            S_WRITE: if (idx_q == IDX_LAST) state_d = S_DONE;
            S_DONE:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q <= '0; diff_q <= 1'b0; uni_q <= 1'b0; root_q <= 1'b0;
            cmd_q <= CMD_READY; idx_q <= '0; err_q <= ERR_NONE; line60_q <= 1'b1;
        end else begin
            if (state_q == S_IDLE && cmd_i != CMD_READY) begin
                ch_q   <= chan_i;
                diff_q <= diff_i;
                uni_q  <= uni_i;
                root_q <= root_i;
                cmd_q  <= cmd_i;
                idx_q  <= '0;
                err_q  <= ERR_NONE;
            end
            if (state_q == S_CHECK) begin
                if (chan_cmd)           err_q    <= err_chk;
                if (cmd_q == CMD_F50)   line60_q <= 1'b0;
                if (cmd_q == CMD_F60)   line60_q <= 1'b1;
            end
            if ((state_q == S_READ || state_q == S_WRITE) && idx_q != IDX_LAST)
                idx_q <= idx_q + 1'b1;
        end
    end

    always_comb begin
        fsm_busy = (state_q != S_IDLE);
        done     = (state_q == S_DONE);
        ld_en    = (state_q == S_READ);
        wr_en    = (state_q == S_WRITE);
        set_en   = (state_q == S_WRITE) && (idx_q == IDX_LAST);
        clr_en   = (state_q == S_RESET);
    end

    assign pair_o   = diff_q;
    assign ch_o     = ch_q;
    assign idx_o    = idx_q;
    assign err_o    = err_q;
    assign line60_o = line60_q;

    AST_RESET_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RESET) |=> !cfg_i[ch_q]); // R4
    AST_WRITE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WRITE && idx_q == IDX_LAST) |=> cfg_i[ch_q]); // R2
    AST_REJECT_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && chan_cmd && err_chk != ERR_NONE) |=> $stable(cfg_i)); // R7
    AST_ODD_PAIR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && chan_cmd && diff_q && ch_q[0]) |=> (err_q == ERR_ODD_PAIR)); // R7
    AST_ROOT_BIPOLAR_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_CHECK && cmd_q == CMD_WRITE && !(diff_q && ch_q[0]) && root_q && !uni_q)
        |=> (err_q == ERR_ROOT_BIPOLAR)); // R8
endmodule

// File: rtl/ccc_top.sv
module ccc_top
    import ccc_pkg::*;
#(
    parameter int NUM_CH    = 16,
    parameter int NUM_PARAM = 7,
    parameter int ADDR_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_we,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [15:0]       host_wdata,
    output logic [15:0]       host_rdata,
    output logic              busy,
    output logic [NUM_CH-1:0] chan_ready,
    output logic              cfg_err,
    output logic [1:0]        err_code,
    output logic              line_60hz
);
    localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int IDX_W = (NUM_PARAM > 1) ? $clog2(NUM_PARAM) : 1;

    logic                    fsm_busy, done, ld_en, wr_en, set_en, clr_en, pair, line60;
    logic [3:0]              cmd;
    logic [CH_W-1:0]         chan, st_ch;
    logic                    diff, uni, root;
    logic [IDX_W-1:0]        idx;
    logic [DW-1:0]           rd_word, wr_word;
    logic [NUM_PARAM*DW-1:0] param_flat;
    logic [NUM_CH-1:0]       cfg, dmode;
    err_e                    err;

    assign wr_word = param_flat[int'(idx)*DW +: DW];

    ccc_host_regs #(.NUM_CH(NUM_CH), .NUM_PARAM(NUM_PARAM), .ADDR_W(ADDR_W),
                    .CH_W(CH_W), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .rdata(host_rdata), .fsm_busy(fsm_busy), .done(done), .ld_en(ld_en),
        .ld_idx(idx), .ld_data(rd_word), .status(cfg), .err(err), .line60(line60),
        .busy(busy), .cmd(cmd), .chan(chan), .diff(diff), .uni(uni), .root(root),
        .param_flat(param_flat));

    ccc_cmd_fsm #(.NUM_CH(NUM_CH), .NUM_PARAM(NUM_PARAM), .CH_W(CH_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd), .chan_i(chan), .diff_i(diff), .uni_i(uni),
        .root_i(root), .cfg_i(cfg), .dmode_i(dmode), .fsm_busy(fsm_busy), .done(done),
        .ld_en(ld_en), .wr_en(wr_en), .set_en(set_en), .clr_en(clr_en), .pair_o(pair),
        .ch_o(st_ch), .idx_o(idx), .err_o(err), .line60_o(line60));

    ccc_cfg_store #(.NUM_CH(NUM_CH), .NUM_PARAM(NUM_PARAM), .CH_W(CH_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .ch(st_ch), .idx(idx), .wr_en(wr_en), .wr_data(wr_word),
        .rd_data(rd_word), .set_en(set_en), .clr_en(clr_en), .pair(pair),
        .cfg_o(cfg), .dmode_o(dmode));

    assign chan_ready = cfg;
    assign err_code   = err;
    assign cfg_err    = (err != ERR_NONE);
    assign line_60hz  = line60;

    AST_ERR_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_err) |-> $stable(chan_ready)); // R7
endmodule

// File: tb/sim_ccc_top.sv
`timescale 1ns/1ps
module sim_ccc_top;
    localparam int NP = 7;
    localparam int A_CHAN = NP, A_CTRL = NP + 1, A_STAT = NP + 2, A_ERR = NP + 3;
    localparam int K_REG = 0, K_READY = 1, K_BUSY = 2, K_CFGERR = 3, K_ERRCODE = 4;

    logic        clk = 1'b0, rst_n = 1'b0, host_we = 1'b0;
    logic [3:0]  host_addr = '0;
    logic [15:0] host_wdata = '0, host_rdata;
    logic        busy, cfg_err, line_60hz;
    logic [15:0] chan_ready;
    logic [1:0]  err_code;

    always #4 clk = ~clk;

    ccc_top u0 (.clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
                .host_wdata(host_wdata), .host_rdata(host_rdata), .busy(busy),
                .chan_ready(chan_ready), .cfg_err(cfg_err), .err_code(err_code),
                .line_60hz(line_60hz));

    typedef struct { int kind; int exp; string tag; } item_t;
    item_t q[$];
    event  mon_ev;
    bit    pending = 0, finished = 0;
    int    n_cmp = 0, n_bad = 0;

    initial begin : monitor
        forever begin
            @(mon_ev);
            while (q.size() > 0) begin
                item_t it;
                int    act;
                it = q.pop_front();
                case (it.kind)
                    K_READY:   act = int'(chan_ready);
                    K_BUSY:    act = int'(busy);
                    K_CFGERR:  act = int'(cfg_err);
                    K_ERRCODE: act = int'(err_code);
                    default:   act = int'(host_rdata);
                endcase
                n_cmp++;
                if (act != it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
            pending = 0;
        end
    end

    task automatic chk(input int kind, input int a, input int exp, input string tag);
        item_t it;
        host_addr = a[3:0];
        #1;
        it.kind = kind; it.exp = exp; it.tag = tag;
        q.push_back(it);
        pending = 1;
        -> mon_ev;
        wait (pending == 0);
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a[3:0]; host_wdata = d[15:0];
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 64 && busy; i++) @(negedge clk);
    endtask

    function automatic int ctl(int cmd, bit dif, bit un, bit rt);
        return (cmd << 12) | (int'(un) << 9) | (int'(dif) << 8) | (int'(rt) << 7);
    endfunction

    task automatic run(input int c);
        wr(A_CTRL, c);
        wait_idle();
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            summary();
            $finish;
        end
    end

    initial begin : driver
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(K_READY, 0, 0, "R1 ready bits");
        chk(K_REG, A_ERR, 'h10, "R1 error/60Hz");
        chk(K_REG, A_CTRL, 0, "R1 control");
        chk(K_BUSY, 0, 0, "R1 busy");
        // R2 single-ended write of channel 1
        for (int i = 0; i < NP; i++) wr(i, 'h1100 + i);
        wr(A_CHAN, 1);
        run(ctl(3, 0, 0, 0));
        chk(K_REG, A_STAT, 'h0002, "R2 status after write");
        chk(K_REG, A_ERR, 'h10, "R2 no error");
        chk(K_REG, A_CTRL, 0, "R5 command back to ready");
        chk(K_BUSY, 0, 0, "R5 busy low");
        // R3 read back
        for (int i = 0; i < NP; i++) wr(i, 'hFFFF);
        run(ctl(2, 0, 0, 0));
        for (int i = 0; i < NP; i++) chk(K_REG, i, 'h1100 + i, "R3 read back word");
        // R6 differential pair on 4
        for (int i = 0; i < NP; i++) wr(i, 'h40 + i);
        wr(A_CHAN, 4);
        run(ctl(3, 1, 0, 0));
        chk(K_READY, 0, 'h0032, "R6 pair ready bits");
        // R7 odd pair channel
        wr(A_CHAN, 5);
        run(ctl(3, 1, 0, 0));
        chk(K_REG, A_ERR, 'h11, "R7 odd channel error");
        chk(K_CFGERR, 0, 1, "R7 cfg_err");
        chk(K_READY, 0, 'h0032, "R7 status unchanged");
        // R8 root with bipolar
        wr(A_CHAN, 6);
        run(ctl(3, 0, 0, 1));
        chk(K_ERRCODE, 0, 2, "R8 root bipolar error");
        chk(K_READY, 0, 'h0032, "R8 not stored");
        run(ctl(3, 0, 1, 1));
        chk(K_READY, 0, 'h0072, "R8 unipolar root accepted");
        chk(K_REG, A_ERR, 'h10, "R12 error cleared");
        chk(K_CFGERR, 0, 0, "R12 cfg_err low");
        // R9 mode switch
        wr(A_CHAN, 4);
        run(ctl(3, 0, 0, 0));
        chk(K_REG, A_ERR, 'h13, "R9 mode switch error");
        chk(K_READY, 0, 'h0072, "R9 status unchanged");
        run(ctl(1, 1, 0, 0));
        chk(K_READY, 0, 'h0042, "R6 pair reset clears both");
        run(ctl(3, 0, 0, 0));
        chk(K_READY, 0, 'h0052, "R9 write after reset");
        chk(K_ERRCODE, 0, 0, "R9 no error after reset");
        // R4 reset clears params
        wr(A_CHAN, 1);
        run(ctl(1, 0, 0, 0));
        chk(K_READY, 0, 'h0050, "R4 ready bit cleared");
        run(ctl(2, 0, 0, 0));
        chk(K_REG, 0, 0, "R4 word 0 cleared");
        chk(K_REG, NP - 1, 0, "R4 last word cleared");
        // R10 frequency
        run(ctl(4, 0, 0, 0));
        chk(K_REG, A_ERR, 'h00, "R10 50 Hz");
        run(ctl(5, 0, 0, 0));
        chk(K_REG, A_ERR, 'h10, "R10 60 Hz");
        // R11 writes ignored while busy
        for (int i = 0; i < NP; i++) wr(i, 'h2200 + i);
        wr(A_CHAN, 2);
        wr(A_CTRL, ctl(3, 0, 0, 0));
        chk(K_BUSY, 0, 1, "R11 busy during command");
        wr(A_CHAN, 9);
        wr(0, 'hBEEF);
        wr(A_CTRL, ctl(1, 0, 0, 0));
        wait_idle();
        chk(K_REG, A_CHAN, 2, "R11 channel kept");
        chk(K_REG, 0, 'h2200, "R11 parameter kept");
        chk(K_REG, A_CTRL, 0, "R11 reset command dropped");
        chk(K_READY, 0, 'h0054, "R11 write completed");
        finished = 1;
        summary();
        $finish;
    end
endmodule